// File: doc/BRIEF.md
# Bunch-Crossing Identification Gate

This block assigns discriminated detector hits to bunch crossings. It has two independent ports, each fed by a 16-channel front-end board. The block runs on an oversampling clock at eight ticks per crossing period. On each channel the hit level is first corrected for polarity and masked. It is then delayed by a whole number of ticks that the port's signal-delay setting selects. A rising edge of that level opens a gate that lasts a programmable number of ticks, between 8 and 16. A gate can therefore stay open for up to two crossing periods, so a late hit is still attributed to a single crossing. When the gate closes, the channel emits a pulse one crossing long. The pulse starts on the next crossing strobe of its port.

Each port finds its crossing strobe by comparing a shared tick-phase counter with the port's clock-delay setting. Both delay settings arrive as plain input values. The channel mask and the gate width of each port sit in a small write-only register file. A global bypass pin skips the gate logic. In bypass each output follows the polarity-corrected, masked hit one tick later.

Top module: `bcid_gate_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every hit output goes to 0, all masks go to 0, both gate widths go to 8 ticks and the tick phase goes to 0.
- R2: The phase counts 0 to 7 and wraps, starting at 0 in the first tick after reset. `bc_strobe_o[p]` is high exactly while the phase equals port p's clock-delay value.
- R3: The processed hit of a port is delayed by `sig_dly` ticks, from 0 to 7, before it reaches the gate logic.
- R4: When the delayed hit rises at tick T on a channel whose gate is closed, the gate covers ticks T to T+W-1. W is the port's gate width.
- R5: A rising edge during ticks T+1 to T+W-1 of an open gate is merged into that gate. It neither extends the gate nor opens a second one.
- R6: When a gate ends at tick C, that channel's output is high for exactly 8 ticks. The pulse starts one tick after the first strobe tick of its port that lies strictly after C. A strobe with nothing pending drives the output to 0.
- R7: Bit c of a port's mask set to 1 suppresses channel c of that port, both in gated operation and in bypass.
- R8: With `pol_i[p]` = 1, the hits of port p are active-low. With 0 they are active-high.
- R9: With `bypass_i` high, each output equals that channel's polarity-corrected, masked, undelayed input, one tick later.
- R10: A register write takes effect one tick later. `cfg_addr_i[1]` selects the port. `cfg_addr_i[0]` = 0 writes the 16-bit mask and 1 writes the gate width from `cfg_wdata_i[4:0]`. The width is clamped into the range 8 to 16.
- R11: The two ports are independent. Each uses only its own hits, mask, width, polarity and delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight ticks per crossing |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 32 | Raw hit lines, port p at bits [16p+15:16p] |
| pol_i | input | 2 | Per-port polarity, 1 = active-low |
| bypass_i | input | 1 | Bypass of the gate logic |
| sig_dly_i | input | 6 | Per-port signal delay in ticks, 3 bits each |
| bc_dly_i | input | 6 | Per-port crossing strobe phase, 3 bits each |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address {port, field} |
| cfg_wdata_i | input | 16 | Register write data |
| bc_strobe_o | output | 2 | Per-port crossing strobe |
| hit_o | output | 32 | Crossing-aligned hit outputs, same layout as hit_i |

## Verification
The strobe is combinational on the phase register, so it is due in the tick whose phase matches. Bypass outputs and register writes take effect one tick after they are applied. A gated pulse follows a hit's arrival by the signal delay, plus the gate width, plus the wait for the next strobe, plus one register stage. That total ranges from about 9 to 31 ticks. The bench steps a tick-level reference model with each applied input vector and compares every output at the following falling edge. Each result is therefore judged in exactly the tick in which the requirements place it, never earlier or later.

// File: rtl/bcid_pkg.sv
// Shared types and helpers for the bunch-crossing gate.
// Assumes: register field select is a single address bit.
package bcid_pkg;

    // Register field selected by the low address bit.
    typedef enum logic {
        FLD_MASK = 1'b0,
        FLD_GATE = 1'b1
    } cfg_fld_e;

    // Clamp a requested gate width into the legal window.
    function automatic int clamp_gw(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/bcid_phase.sv
// Tick-phase counter inside one crossing period.
// Assumes: OVS ticks per crossing, counter restarts at 0 on reset.
module bcid_phase #(
    parameter int OVS  = 8,
    localparam int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph_o
);

    logic [PH_W-1:0] ph_q;

    // Count ticks modulo OVS.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ph_q <= '0;
        else if (ph_q == PH_W'(OVS - 1))    ph_q <= '0;
        else                                ph_q <= ph_q + 1'b1;
    end

    assign ph_o = ph_q;

endmodule

// File: rtl/bcid_cfg.sv
// Write-only configuration: per-port channel mask and gate width.
// Assumes: address = {port index, field bit}; width writes are clamped.
module bcid_cfg
    import bcid_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_CH    = 16,
    parameter int GW_MIN    = 8,
    parameter int GW_MAX    = 16,
    parameter int GW_DEF    = 8,
    localparam int GW_W     = $clog2(GW_MAX + 1),
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int AW       = PORT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [NUM_CH-1:0]           wdata_i,
    output logic [NUM_PORTS*NUM_CH-1:0] mask_o,
    output logic [NUM_PORTS*GW_W-1:0]   gw_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [NUM_CH-1:0] mask_q;
        logic [GW_W-1:0]   gw_q;
        logic              sel;

        assign sel = we_i && (addr_i[AW-1:1] == PORT_W'(p));

        // Update the addressed field of this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                gw_q   <= GW_W'(GW_DEF);
            end else if (sel) begin
                if (cfg_fld_e'(addr_i[0]) == FLD_MASK)
                    mask_q <= wdata_i;
                else
                    gw_q <= GW_W'(clamp_gw(int'(wdata_i[GW_W-1:0]), GW_MIN, GW_MAX));
            end
        end

        assign mask_o[p*NUM_CH +: NUM_CH] = mask_q;
        assign gw_o[p*GW_W +: GW_W]       = gw_q;

        // R10
        gw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gw_q >= GW_W'(GW_MIN)) && (gw_q <= GW_W'(GW_MAX)));
    end

endmodule

// File: rtl/bcid_chan.sv
// One channel: rising-edge gate, pending flag and crossing-aligned output.
// Assumes: gw_i >= 2; strobe_i is high for one tick per crossing.
module bcid_chan #(
    parameter int GW_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic            byp_hit_i,
    input  logic            bypass_i,
    input  logic            strobe_i,
    input  logic [GW_W-1:0] gw_i,
    output logic            out_o
);

    logic            prev_q;
    logic            open_q;
    logic [GW_W-1:0] cnt_q;
    logic            pend_q;
    logic            out_q;
    logic            rise;
    logic            close;

    assign rise  = hit_i & ~prev_q;
    assign close = open_q && (cnt_q == GW_W'(1));

    // Edge history of the delayed hit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= hit_i;
    end

    // Gate window: opens on a rise while closed, runs for gw_i ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!open_q) begin
            if (rise) begin
                open_q <= 1'b1;
                cnt_q  <= gw_i - 1'b1;
            end
        end else if (close) begin
            open_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pending result: set by a closing gate, consumed by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (strobe_i) pend_q <= close;
        else if (close)    pend_q <= 1'b1;
    end

    // Output register: bypass follows input, otherwise loaded per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= 1'b0;
        else if (bypass_i) out_q <= byp_hit_i;
        else if (strobe_i) out_q <= pend_q;
    end

    assign out_o = out_q;

    // R4
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (cnt_q != '0));

    // R6
    pend_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_q) |-> pend_q);

endmodule

// File: rtl/bcid_port.sv
// One port: polarity, mask, tick delay line, strobe decode, channel gates.
// Assumes: delays are in ticks below OVS; mask and width come registered.
module bcid_port #(
    parameter int NUM_CH = 16,
    parameter int OVS    = 8,
    parameter int GW_W   = 5,
    localparam int PH_W  = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_i,
    input  logic              pol_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [PH_W-1:0]   sig_dly_i,
    input  logic [PH_W-1:0]   bc_dly_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic              bypass_i,
    input  logic [GW_W-1:0]   gw_i,
    output logic              strobe_o,
    output logic [NUM_CH-1:0] out_o
);

    logic [NUM_CH-1:0] hpol;
    logic [NUM_CH-1:0] tap_q [OVS-1];
    logic [NUM_CH-1:0] dly_hit;

    assign hpol     = (raw_i ^ {NUM_CH{pol_i}}) & ~mask_i;
    assign strobe_o = (ph_i == bc_dly_i);

    // Tick delay line holding the last OVS-1 processed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < OVS - 1; k++) tap_q[k] <= '0;
        end else begin
            tap_q[0] <= hpol;
            for (int k = 1; k < OVS - 1; k++) tap_q[k] <= tap_q[k-1];
        end
    end

    // Pick the tap matching the programmed signal delay.
    always_comb begin
        dly_hit = hpol;
        for (int k = 1; k < OVS; k++)
            if (sig_dly_i == PH_W'(k)) dly_hit = tap_q[k-1];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bcid_chan #(.GW_W(GW_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (dly_hit[c]),
            .byp_hit_i (hpol[c]),
            .bypass_i  (bypass_i),
            .strobe_i  (strobe_o),
            .gw_i      (gw_i),
            .out_o     (out_o[c])
        );
    end

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bypass_i) && !$past(strobe_o)) |-> $stable(out_o));

    // R7
    byp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bypass_i) |-> ((out_o & $past(mask_i)) == '0));

endmodule

// File: rtl/bcid_gate_top.sv
// Two-port bunch-crossing gate: shared phase counter, config registers,
// and one port slice per front-end board.
// Assumes: clk runs at OVS ticks per crossing; reset is synchronous.
module bcid_gate_top #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_CH    = 16,
    parameter int OVS       = 8,
    parameter int GW_MIN    = 8,
    parameter int GW_MAX    = 16,
    parameter int GW_DEF    = 8,
    localparam int PH_W     = $clog2(OVS),
    localparam int GW_W     = $clog2(GW_MAX + 1),
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int AW       = PORT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*NUM_CH-1:0] hit_i,
    input  logic [NUM_PORTS-1:0]        pol_i,
    input  logic                        bypass_i,
    input  logic [NUM_PORTS*PH_W-1:0]   sig_dly_i,
    input  logic [NUM_PORTS*PH_W-1:0]   bc_dly_i,
    input  logic                        cfg_we_i,
    input  logic [AW-1:0]               cfg_addr_i,
    input  logic [NUM_CH-1:0]           cfg_wdata_i,
    output logic [NUM_PORTS-1:0]        bc_strobe_o,
    output logic [NUM_PORTS*NUM_CH-1:0] hit_o
);

    logic [PH_W-1:0]               ph;
    logic [NUM_PORTS*NUM_CH-1:0]   mask;
    logic [NUM_PORTS*GW_W-1:0]     gw;

    bcid_phase #(.OVS(OVS)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_o  (ph)
    );

    bcid_cfg #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_CH    (NUM_CH),
        .GW_MIN    (GW_MIN),
        .GW_MAX    (GW_MAX),
        .GW_DEF    (GW_DEF)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .mask_o  (mask),
        .gw_o    (gw)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        bcid_port #(
            .NUM_CH (NUM_CH),
            .OVS    (OVS),
            .GW_W   (GW_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_i     (hit_i[p*NUM_CH +: NUM_CH]),
            .pol_i     (pol_i[p]),
            .mask_i    (mask[p*NUM_CH +: NUM_CH]),
            .sig_dly_i (sig_dly_i[p*PH_W +: PH_W]),
            .bc_dly_i  (bc_dly_i[p*PH_W +: PH_W]),
            .ph_i      (ph),
            .bypass_i  (bypass_i),
            .gw_i      (gw[p*GW_W +: GW_W]),
            .strobe_o  (bc_strobe_o[p]),
            .out_o     (hit_o[p*NUM_CH +: NUM_CH])
        );
    end

endmodule

// File: tb/tb_bcid_gate_top.sv
module tb_bcid_gate_top;
    localparam int NP = 2, NC = 16, OV = 8, PW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [NP*NC-1:0]  hit_i;
    logic [NP-1:0]     pol_i;
    logic              bypass_i;
    logic [NP*PW-1:0]  sig_dly_i, bc_dly_i;
    logic              cfg_we_i;
    logic [1:0]        cfg_addr_i;
    logic [NC-1:0]     cfg_wdata_i;
    wire  [NP-1:0]     bc_strobe_o;
    wire  [NP*NC-1:0]  hit_o;

    bcid_gate_top dut (.*);

    int vectors = 0, fails = 0, t_now = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int       m_ph;
    bit [NC-1:0] m_mask [NP];
    int       m_gw [NP];
    bit [NC-1:0] hist [NP][OV];
    bit       prv  [NP][NC];
    int       st   [NP][NC];
    int       en   [NP][NC];
    bit       pend [NP][NC];
    bit [NC-1:0] mout [NP];

    function automatic int clampw(int v);
        return (v < 8) ? 8 : (v > 16) ? 16 : v;
    endfunction

    task automatic model_reset();
        m_ph = 0;
        for (int p = 0; p < NP; p++) begin
            m_mask[p] = '0; m_gw[p] = 8; mout[p] = '0;
            for (int k = 0; k < OV; k++) hist[p][k] = '0;
            for (int c = 0; c < NC; c++) begin
                prv[p][c] = 0; st[p][c] = -100; en[p][c] = -100; pend[p][c] = 0;
            end
        end
    endtask

    task automatic model_step();
        t_now++;
        if (!rst_n) begin model_reset(); return; end
        for (int p = 0; p < NP; p++) begin
            bit [NC-1:0] hp;
            bit [NC-1:0] sel;
            bit strobe;
            hp = (hit_i[p*NC +: NC] ^ {NC{pol_i[p]}}) & ~m_mask[p];
            for (int k = OV - 1; k > 0; k--) hist[p][k] = hist[p][k-1];
            hist[p][0] = hp;
            sel = hist[p][sig_dly_i[p*PW +: PW]];
            strobe = (m_ph == int'(bc_dly_i[p*PW +: PW]));
            for (int c = 0; c < NC; c++) begin
                bit rise, opn, cls;
                rise = sel[c] && !prv[p][c];
                prv[p][c] = sel[c];
                opn = (st[p][c] < t_now) && (t_now <= en[p][c]);
                cls = opn && (t_now == en[p][c]);
                if (!opn && rise) begin
                    st[p][c] = t_now; en[p][c] = t_now + m_gw[p] - 1;
                end
                if (bypass_i) mout[p][c] = hp[c];
                else if (strobe) mout[p][c] = pend[p][c];
                if (strobe) pend[p][c] = cls;
                else if (cls) pend[p][c] = 1;
            end
        end
        m_ph = (m_ph + 1) % OV;
        if (cfg_we_i) begin
            if (cfg_addr_i[0] == 1'b0) m_mask[cfg_addr_i[1]] = cfg_wdata_i;
            else m_gw[cfg_addr_i[1]] = clampw(int'(cfg_wdata_i[4:0]));
        end
    endtask

    task automatic check_outputs();
        for (int p = 0; p < NP; p++) begin
            bit es;
            es = (m_ph == int'(bc_dly_i[p*PW +: PW]));
            vectors++;
            if (bc_strobe_o[p] !== es) begin
                fails++;
                $display("FAIL R2 port%0d strobe act=%b exp=%b t=%0d", p, bc_strobe_o[p], es, t_now);
            end
            vectors++;
            if (hit_o[p*NC +: NC] !== mout[p]) begin
                fails++;
                $display("FAIL %s port%0d hit_o act=%h exp=%h t=%0d", cur_req, p, hit_o[p*NC +: NC], mout[p], t_now);
            end
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            check_outputs();
        end
    endtask

    task automatic wr(bit [1:0] a, bit [NC-1:0] d);
        cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
        cyc(1);
        cfg_we_i = 0;
    endtask

    task automatic rand_hits(int n, int rate);
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < NP*NC; b++) hit_i[b] = ($urandom % rate) == 0;
            cyc(1);
        end
        hit_i = '0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; hit_i = '0; pol_i = '0; bypass_i = 0;
        sig_dly_i = '0; bc_dly_i = '0; cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0;
        model_reset();
        cur_req = "R1 reset";
        cyc(3);
        rst_n = 1;
        cyc(2);
        cur_req = "R1 defaults";
        hit_i[0] = 1; cyc(1); hit_i = '0; cyc(30);

        // R4/R6: wide gate on port 0, single hit
        cur_req = "R4 R6 wide gate";
        wr(2'b01, 16'd16);
        cyc(5);
        hit_i[3] = 1; cyc(1); hit_i = '0; cyc(40);

        // R5: second rise inside open gate merges
        cur_req = "R5 merge";
        hit_i[5] = 1; cyc(1); hit_i = '0; cyc(4);
        hit_i[5] = 1; cyc(1); hit_i = '0; cyc(40);

        // R3: signal delay and clock delay differ per port
        cur_req = "R3 delay";
        sig_dly_i = {3'd2, 3'd5}; bc_dly_i = {3'd6, 3'd3};
        rand_hits(400, 25); cyc(40);

        // R7: mask on port 1
        cur_req = "R7 mask";
        wr(2'b10, 16'h00FF);
        rand_hits(400, 15); cyc(40);

        // R8: active-low on port 0
        cur_req = "R8 polarity";
        pol_i = 2'b01;
        rand_hits(400, 20); cyc(40);
        pol_i = 2'b00; cyc(40);

        // R9: bypass, masked lanes remain 0 (R7)
        cur_req = "R9 bypass";
        bypass_i = 1;
        rand_hits(200, 4);
        bypass_i = 0; cyc(40);

        // R10: clamped width writes
        cur_req = "R10 clamp low";
        wr(2'b01, 16'd3); wr(2'b11, 16'hFFFF);
        rand_hits(300, 30); cyc(40);
        cur_req = "R10 clamp high";
        wr(2'b01, 16'd31); wr(2'b11, 16'd2);
        rand_hits(300, 30); cyc(40);

        // R11: random mix, independent ports
        cur_req = "R11 random mix";
        for (int blk = 0; blk < 12; blk++) begin
            sig_dly_i = PW*NP'($urandom);
            bc_dly_i  = PW*NP'($urandom);
            pol_i     = NP'($urandom);
            bypass_i  = ($urandom % 5) == 0;
            wr(2'($urandom), NC'($urandom));
            rand_hits(150, 8 + ($urandom % 20));
            bypass_i = 0; cyc(40);
        end

        // R1: reset mid-run
        cur_req = "R1 mid reset";
        hit_i = '1; cyc(3);
        rst_n = 0; cyc(2); rst_n = 1; hit_i = '0; cyc(40);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule